// File: doc/BRIEF.md
# HDLC Receive Line Status Monitor

This block watches the recovered bit stream of a serial HDLC receiver and reports three live line conditions: whether opening/closing flags are arriving, whether the upstream clock-recovery stage senses a carrier, and whether the line has gone idle. A bit-valid strobe marks each recovered bit time. All flag and idle detection logic advances only on strobed cycles. The carrier input is sampled on every clock.

The three conditions are packed into an 8-bit read-only status byte and are also brought out as separate wires. The flag indicator is not a single-cycle pulse. Once a flag is seen, it is held for a full 8-bit observation window. It is re-armed only when another flag completes within that window. Idle needs an uninterrupted run of ones.

Top module: `hdlc_line_monitor`

## Requirements
- R1: Synchronous reset drives `status_byte` to 0x00 and clears the bit history, the bit-fill count, the hold count and the ones count.
- R2: After reset, no flag is reported until at least 8 strobed bits have been received. Seven bits 1,1,1,1,1,1,0 sent straight after reset leave the flag bit at 0.
- R3: On the strobe whose bit completes the pattern 0x7E in the last 8 received bits (oldest bit first), the flag bit reads 1 from the next clock on. The search slides, so any bit alignment is found.
- R4: After a flag match with no further match, the flag bit stays 1 through the next 7 strobes and reads 0 after the 8th.
- R5: A new flag that completes on any of the 8 strobes after a match, including the 8th, restarts the 8-bit hold.
- R6: The idle bit becomes 1 on the strobe carrying the 15th consecutive 1. It is still 0 after 14.
- R7: The ones counter saturates, so idle stays 1 over arbitrarily long runs of ones. A single strobed 0 clears idle at the next clock.
- R8: `carrier_sense` equals `carrier_in` as sampled at the previous clock edge, whether or not a bit is strobed.
- R9: On cycles with `bit_valid` low, the flag bit, the idle bit and the hold progress do not change, whatever `rx_bit` does.
- R10: `status_byte` bit 0 is idle, bit 1 is carrier sense, bit 2 is the flag, and bits 7..3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Marks a cycle carrying a recovered bit |
| rx_bit | input | 1 | Recovered receive data bit |
| carrier_in | input | 1 | Carrier indication from clock recovery |
| status_byte | output | 8 | Packed status: bit 2 flag, bit 1 carrier, bit 0 idle |
| flag_seen | output | 1 | Flags are being received |
| carrier_sense | output | 1 | Registered carrier indication |
| line_idle | output | 1 | Line idle (run of ones) |

## Verification
The flag detector is driven with:
- a 7-bit pattern straight after reset that matches only against the zeroed history;
- a flag followed by zeros;
- back-to-back flags;
- flags sharing a zero.

Together these separate the fill guard, the exact hold length, extension on the last window bit and extension mid-window. The idle logic is given runs of 14, 15 and more than 40 ones, then a single zero, to locate the threshold and show saturation. Gaps with `bit_valid` low while `rx_bit` toggles show that neither the history nor the hold count advances between strobes.

// File: rtl/hdlc_mon_pkg.sv
package hdlc_mon_pkg;
  localparam int STAT_W    = 8;
  localparam int STAT_IDLE = 0;
  localparam int STAT_CARR = 1;
  localparam int STAT_FLAG = 2;
  localparam int STAT_USED = 3;
endpackage

// File: rtl/flag_hunter.sv
module flag_hunter #(
  parameter int              FLAG_W       = 8,
  parameter logic [FLAG_W-1:0] FLAG_PATTERN = 8'h7E
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic din,
  output logic flag_o
);
  localparam int CNT_W = $clog2(FLAG_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FLAG_W);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [FLAG_W-1:0] hist, hist_next;
  logic [CNT_W-1:0]  fill, fill_next, hold;
  logic              match;

  always_comb begin
    hist_next = {hist[FLAG_W-2:0], din};
    fill_next = (fill == FULL) ? fill : fill + ONE;
    match     = (fill_next == FULL) && (hist_next == FLAG_PATTERN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist   <= '0;
      fill   <= '0;
      hold   <= '0;
      flag_o <= 1'b0;
    end else if (strobe) begin
      hist <= hist_next;
      fill <= fill_next;
      if (match) begin
        flag_o <= 1'b1;
        hold   <= FULL;
      end else if (flag_o) begin
        if (hold == ONE) begin
          flag_o <= 1'b0;
          hold   <= '0;
        end else begin
          hold <= hold - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/idle_tracker.sv
module idle_tracker #(
  parameter int IDLE_RUN = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic din,
  output logic idle_o
);
  localparam int RUN_W = $clog2(IDLE_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(IDLE_RUN);
  localparam logic [RUN_W-1:0] RUN_PRE = RUN_W'(IDLE_RUN - 1);

  logic [RUN_W-1:0] ones;

  always_ff @(posedge clk) begin
    if (rst) begin
      ones   <= '0;
      idle_o <= 1'b0;
    end else if (strobe) begin
      if (!din) begin
        ones   <= '0;
        idle_o <= 1'b0;
      end else begin
        if (ones != RUN_MAX) ones <= ones + RUN_W'(1);
        idle_o <= (ones >= RUN_PRE);
      end
    end
  end
endmodule

// File: rtl/hdlc_line_monitor.sv
module hdlc_line_monitor
  import hdlc_mon_pkg::*;
#(
  parameter int IDLE_RUN = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_valid,
  input  logic              rx_bit,
  input  logic              carrier_in,
  output logic [STAT_W-1:0] status_byte,
  output logic              flag_seen,
  output logic              carrier_sense,
  output logic              line_idle
);
  flag_hunter #(.FLAG_W(8), .FLAG_PATTERN(8'h7E)) u_flag (
    .clk(clk), .rst(rst), .strobe(bit_valid), .din(rx_bit), .flag_o(flag_seen)
  );

  idle_tracker #(.IDLE_RUN(IDLE_RUN)) u_idle (
    .clk(clk), .rst(rst), .strobe(bit_valid), .din(rx_bit), .idle_o(line_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) carrier_sense <= 1'b0;
    else     carrier_sense <= carrier_in;
  end

  always_comb begin
    status_byte[STAT_IDLE] = line_idle;
    status_byte[STAT_CARR] = carrier_sense;
    status_byte[STAT_FLAG] = flag_seen;
  end

  for (genvar g = STAT_USED; g < STAT_W; g++) begin : g_rsvd
    assign status_byte[g] = 1'b0;
  end
endmodule

// File: rtl/hdlc_line_monitor_chk.sv
module hdlc_line_monitor_chk (
  input logic       clk,
  input logic       rst,
  input logic       bit_valid,
  input logic       rx_bit,
  input logic       carrier_in,
  input logic [7:0] status_byte,
  input logic       flag_seen,
  input logic       carrier_sense,
  input logic       line_idle
);
  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (status_byte == 8'h00));

  assert_flag_on_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_seen) |-> $past(bit_valid));

  assert_idle_on_one_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(line_idle) |-> $past(bit_valid && rx_bit));

  assert_idle_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !rx_bit) |=> !line_idle);

  assert_carrier_follow_R8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (carrier_sense == $past(carrier_in)));

  assert_hold_gap_R9: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> ($stable(flag_seen) && $stable(line_idle)));

  always_comb begin
    assert_reserved_zero_R10: assert (status_byte[7:3] == 5'b0);
  end
endmodule

bind hdlc_line_monitor hdlc_line_monitor_chk u_chk (
  .clk(clk), .rst(rst), .bit_valid(bit_valid), .rx_bit(rx_bit),
  .carrier_in(carrier_in), .status_byte(status_byte), .flag_seen(flag_seen),
  .carrier_sense(carrier_sense), .line_idle(line_idle)
);

// File: tb/hdlc_line_monitor_test.sv
`timescale 1ns/1ps
module hdlc_line_monitor_test;
  logic       clk = 1'b0;
  logic       rst, bit_valid, rx_bit, carrier_in;
  logic [7:0] status_byte;
  logic       flag_seen, carrier_sense, line_idle;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  hdlc_line_monitor uut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .rx_bit(rx_bit),
    .carrier_in(carrier_in), .status_byte(status_byte), .flag_seen(flag_seen),
    .carrier_sense(carrier_sense), .line_idle(line_idle)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_valid = 1'b0; rx_bit = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // one strobed bit; outputs sampled at the following negedge
  task automatic send_bit(input logic b);
    bit_valid = 1'b1; rx_bit = b;
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic t_reset();
    carrier_in = 1'b0;
    do_reset();
    check("R1 reset byte", status_byte, 8'h00);
  endtask

  task automatic t_fill_guard();
    do_reset();
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    check("R2 seven bits no flag", {7'b0, flag_seen}, 8'h00);
  endtask

  task automatic t_hold_expire();
    do_reset();
    send_byte(8'h7E);
    check("R3 flag after match", {7'b0, flag_seen}, 8'h01);
    check("R10 flag at bit 2", status_byte, 8'h04);
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    check("R4 held after 7 bits", {7'b0, flag_seen}, 8'h01);
    send_bit(1'b0);
    check("R4 cleared after 8 bits", {7'b0, flag_seen}, 8'h00);
  endtask

  task automatic t_sliding();
    do_reset();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    send_byte(8'h7E);
    check("R3 unaligned flag", {7'b0, flag_seen}, 8'h01);
  endtask

  task automatic t_extend_last();
    do_reset();
    send_byte(8'h7E);
    send_byte(8'h7E);
    check("R5 extend on 8th bit", {7'b0, flag_seen}, 8'h01);
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    check("R5 still held", {7'b0, flag_seen}, 8'h01);
    send_bit(1'b0);
    check("R5 cleared after new window", {7'b0, flag_seen}, 8'h00);
  endtask

  task automatic t_extend_shared();
    do_reset();
    send_byte(8'h7E);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0);
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    check("R5 shared-zero flag extends", {7'b0, flag_seen}, 8'h01);
    send_bit(1'b0);
    check("R5 shared-zero window ends", {7'b0, flag_seen}, 8'h00);
  endtask

  task automatic t_gap();
    do_reset();
    send_byte(8'h7E);
    for (int i = 0; i < 6; i++) begin
      rx_bit = ~rx_bit;
      @(negedge clk);
    end
    check("R9 flag stable in gap", {7'b0, flag_seen}, 8'h01);
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    check("R9 hold not advanced in gap", {7'b0, flag_seen}, 8'h01);
    send_bit(1'b0);
    check("R9 hold ends on 8th strobe", {7'b0, flag_seen}, 8'h00);
  endtask

  task automatic t_idle();
    do_reset();
    for (int i = 0; i < 14; i++) send_bit(1'b1);
    check("R6 not idle after 14", {7'b0, line_idle}, 8'h00);
    send_bit(1'b1);
    check("R6 idle after 15", {7'b0, line_idle}, 8'h01);
    for (int i = 0; i < 40; i++) send_bit(1'b1);
    check("R7 idle saturates", {7'b0, line_idle}, 8'h01);
    rx_bit = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 idle kept in gap", {7'b0, line_idle}, 8'h01);
    send_bit(1'b0);
    check("R7 single zero clears", {7'b0, line_idle}, 8'h00);
  endtask

  task automatic t_carrier();
    do_reset();
    carrier_in = 1'b1;
    @(negedge clk);
    check("R8 carrier follows", {7'b0, carrier_sense}, 8'h01);
    check("R10 carrier at bit 1", status_byte, 8'h02);
    for (int i = 0; i < 15; i++) send_bit(1'b1);
    check("R10 idle plus carrier", status_byte, 8'h03);
    carrier_in = 1'b0;
    @(negedge clk);
    check("R8 carrier drops", status_byte, 8'h01);
  endtask

  initial begin
    rst = 1'b1; bit_valid = 1'b0; rx_bit = 1'b0; carrier_in = 1'b0;
    t_reset();
    t_fill_guard();
    t_hold_expire();
    t_sliding();
    t_extend_last();
    t_extend_shared();
    t_gap();
    t_idle();
    t_carrier();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule